// File: doc/BRIEF.md
# Multiplexed Interrupt Priority Vector Unit

This unit collects twenty event interrupt sources (capture/compare channels, overrun flags, compare channels and timer overflows) behind a single shared request line that feeds the main interrupt controller. Each source owns one pending bit, set by hardware when its event fires, and one enable bit. Both are held as vectors of twenty bits and seen by software as two 16-bit words each.

The unit keeps a small vector number up to date at all times. It is 00H when no enabled source is pending; otherwise it is the source index plus one (01H to 14H), and the lowest index has the highest priority. Software reads this number through the register port and uses it to branch to the correct handler. The same read clears the pending bit of the source it reported. The shared request stays asserted until no enabled pending bit remains.

Top module: `mux_irq_vector_unit`

## Requirements
- R1: After reset all enable bits and pending bits are 0, `rd_data` is 0 and `irq_o` is 0.
- R2: An event pulse on `evt_i[k]` sets pending bit k at the next clock edge, whatever the state of its enable bit. Pending bits never set without an event. Pending bits 0..15 read at address 2 (bit k at bit k), and bits 16..19 read at address 3 bits 3:0.
- R3: A write to address 0 loads enable bits 0..15 from `wdata[15:0]`. A write to address 1 loads enable bits 16..19 from `wdata[3:0]`. Reads of these addresses return the bits in the same positions, with bits 15:4 of address 1 reading 0.
- R4: The vector is 0 when no source is both pending and enabled. Otherwise it is k+1, where k is the lowest index that is both pending and enabled.
- R5: A read strobe at address 4 returns the current vector, zero-extended, on `rd_data` one cycle later. In the same cycle it clears the pending bit of the source reported. A vector of 0 clears nothing.
- R6: An event on source k in the same cycle as a clear of pending bit k leaves the bit set.
- R7: `irq_o` is 1 exactly when at least one source is both pending and enabled, so it falls only once every enabled pending bit is cleared.
- R8: A write to address 2 or 3 clears each pending bit whose data bit is 1 (same bit positions as R2). Data bits of 0 leave their pending bits unchanged.
- R9: Each vector read strobe clears exactly one source (the one reported). Every other pending bit keeps its value. `rd_data` holds its value between read strobes, and reads of unmapped addresses (5 to 7) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 20 | One-cycle event pulses, one per source |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered, valid the cycle after `rd_en` |
| irq_o | output | 1 | Shared summary interrupt request |

## Verification
The assertions assume that `evt_i`, `rd_en` and `wr_en` are known (never X) at every clock edge from reset onwards. They also assume that a pending bit can rise only through an event, so no other agent writes the pending state. The stimulus drives every input to 0 from time zero, changes inputs only one nanosecond after a rising edge, and keeps events as single-cycle pulses. Random phases draw addresses over the full 3-bit range, including unmapped ones. They also collide vector reads with events on the reported source.

// File: rtl/mvu_pkg.sv
package mvu_pkg;
  typedef enum logic [1:0] {
    RG_MASK = 2'd0,
    RG_PEND = 2'd1,
    RG_VECT = 2'd2,
    RG_NONE = 2'd3
  } mvu_region_e;
endpackage

// File: rtl/mvu_reset_sync.sv
module mvu_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mvu_pending_bank.sv
module mvu_pending_bank #(
  parameter int NUM_SRC = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] pend_n;
  logic               pend_we;

  // a new event overrides a clear of the same bit
  always_comb begin
    pend_n  = (pend_q & ~clr_i) | evt_i;
    pend_we = |(pend_n ^ pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_we) pend_q <= pend_n;
  end
endmodule

// File: rtl/mvu_prio_enc.sv
module mvu_prio_enc #(
  parameter int NUM_SRC = 20,
  parameter int VEC_W   = 5
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_SRC-1:0] grant_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] req;

  always_comb begin
    req     = pend_i & mask_i;
    vec_o   = '0;
    grant_o = '0;
    // scan from the top so the lowest index is the last to win
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        vec_o      = VEC_W'(i + 1);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
    irq_o = |req;
  end
endmodule

// File: rtl/mvu_regport.sv
module mvu_regport
  import mvu_pkg::*;
#(
  parameter int NUM_SRC   = 20,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int VEC_W     = 5,
  parameter int NUM_WORDS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [NUM_SRC-1:0] grant_i,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [DATA_W-1:0]  rd_data
);
  mvu_region_e        region;
  int                 widx;
  logic [NUM_SRC-1:0] mask_n;
  logic               mask_we;
  logic [DATA_W-1:0]  rd_sel;
  logic [DATA_W-1:0]  rd_n;
  logic [DATA_W-1:0]  rd_q;

  // address decode: enable words, pending words, then the vector
  always_comb begin
    int a;
    a      = int'(addr);
    region = RG_NONE;
    widx   = 0;
    if (a < NUM_WORDS) begin
      region = RG_MASK;
      widx   = a;
    end else if (a < 2 * NUM_WORDS) begin
      region = RG_PEND;
      widx   = a - NUM_WORDS;
    end else if (a == 2 * NUM_WORDS) begin
      region = RG_VECT;
    end
  end

  // enable write and pending clear generation
  always_comb begin
    mask_n = mask_q;
    clr_o  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if ((i / DATA_W) == widx) begin
        if (wr_en && region == RG_MASK) mask_n[i] = wdata[i % DATA_W];
        if (wr_en && region == RG_PEND) clr_o[i]  = wdata[i % DATA_W];
      end
    end
    if (rd_en && region == RG_VECT) clr_o = clr_o | grant_i;
    mask_we = wr_en && (region == RG_MASK);
  end

  // read selection
  always_comb begin
    rd_sel = '0;
    case (region)
      RG_MASK, RG_PEND: begin
        for (int j = 0; j < DATA_W; j++) begin
          if (widx * DATA_W + j < NUM_SRC) begin
            rd_sel[j] = (region == RG_MASK) ? mask_q[widx * DATA_W + j]
                                            : pend_i[widx * DATA_W + j];
          end
        end
      end
      RG_VECT: rd_sel[VEC_W-1:0] = vec_i;
      default: rd_sel = '0;
    endcase
    rd_n = rd_en ? rd_sel : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_n;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/mux_irq_vector_unit.sv
module mux_irq_vector_unit #(
  parameter int NUM_SRC = 20,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_o
);
  localparam int NUM_WORDS = (NUM_SRC + DATA_W - 1) / DATA_W;
  localparam int VEC_W     = $clog2(NUM_SRC + 1);

  logic               rst_sync_n;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] grant;
  logic [VEC_W-1:0]   vec;

  mvu_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mvu_pending_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .evt_i(evt_i), .clr_i(clr), .pend_q(pend_q)
  );

  mvu_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
    .pend_i(pend_q), .mask_i(mask_q), .vec_o(vec), .grant_o(grant), .irq_o(irq_o)
  );

  mvu_regport #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .VEC_W(VEC_W), .NUM_WORDS(NUM_WORDS)
  ) u_port (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pend_i(pend_q), .vec_i(vec), .grant_i(grant),
    .mask_q(mask_q), .clr_o(clr), .rd_data(rd_data)
  );
endmodule

// File: rtl/mvu_checker.sv
module mvu_checker #(
  parameter int NUM_SRC = 20,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int VEC_W   = 5,
  parameter int NUM_WORDS = 2
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  rd_data,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [VEC_W-1:0]   vec
);
  localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(2 * NUM_WORDS);

  logic [NUM_SRC-1:0] vec_oh;
  logic               vec_rd;

  always_comb begin
    vec_oh = '0;
    if (vec != '0) vec_oh = NUM_SRC'(1) << (vec - VEC_W'(1));
    vec_rd = rd_en && (addr == VEC_ADDR);
  end

  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R2
  pend_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_i)) == '0));

  // R4
  vec_select_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec != '0) |-> (((pend_q & mask_q & vec_oh) == vec_oh) &&
                     ((pend_q & mask_q & (vec_oh - NUM_SRC'(1))) == '0)));

  // R7
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == (vec != '0));

  // R5
  vec_read_data_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_rd |=> (rd_data == DATA_W'($past(vec))));

  // R5
  vec_read_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_rd && ((vec_oh & evt_i) == '0)) |=> ((pend_q & $past(vec_oh)) == '0));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind mux_irq_vector_unit mvu_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .VEC_W(VEC_W), .NUM_WORDS(NUM_WORDS)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .evt_i(evt_i), .rd_en(rd_en),
  .addr(addr), .rd_data(rd_data), .irq_o(irq_o), .pend_q(pend_q),
  .mask_q(mask_q), .vec(vec)
);

// File: tb/mux_irq_vector_unit_tb_top.sv
`timescale 1ns/1ps
module mux_irq_vector_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [19:0] evt_i;
  logic        wr_en;
  logic        rd_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rd_data;
  logic        irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // behavioural reference state
  bit [19:0] m_pend;
  bit [19:0] m_mask;
  bit [15:0] m_rd;

  mux_irq_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int ref_vec(bit [19:0] p, bit [19:0] m);
    for (int k = 0; k < 20; k++) if (p[k] && m[k]) return k + 1;
    return 0;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit [19:0] e, input bit w, input bit r,
                            input bit [2:0] a, input bit [15:0] d);
    int v;
    bit [19:0] np;
    v  = ref_vec(m_pend, m_mask);
    np = m_pend;
    if (r) begin
      case (a)
        3'd0: m_rd = m_mask[15:0];
        3'd1: m_rd = {12'h0, m_mask[19:16]};
        3'd2: m_rd = m_pend[15:0];
        3'd3: m_rd = {12'h0, m_pend[19:16]};
        3'd4: m_rd = 16'(v);
        default: m_rd = 16'h0;
      endcase
    end
    if (w && a == 3'd2) np[15:0]  = np[15:0]  & ~d;
    if (w && a == 3'd3) np[19:16] = np[19:16] & ~d[3:0];
    if (r && a == 3'd4 && v != 0) np[v-1] = 1'b0;
    np = np | e;
    if (w && a == 3'd0) m_mask[15:0]  = d;
    if (w && a == 3'd1) m_mask[19:16] = d[3:0];
    m_pend = np;
  endtask

  task automatic cycle(input bit [19:0] e, input bit w, input bit r,
                       input bit [2:0] a, input bit [15:0] d);
    evt_i = e; wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk); #1;
    model_step(e, w, r, a, d);
    chk(int'(rd_data), int'(m_rd), "model rd_data R5/R9");
    chk(int'(irq_o), int'(|(m_pend & m_mask)), "model irq R7");
    evt_i = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input bit [2:0] a);       cycle('0, 0, 1, a, '0); endtask
  task automatic wr(input bit [2:0] a, input bit [15:0] d); cycle('0, 1, 0, a, d); endtask
  task automatic ev(input bit [19:0] e);      cycle(e, 0, 0, '0, '0); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; evt_i = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    m_pend = '0; m_mask = '0; m_rd = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a));
      chk(int'(rd_data), 0, "R1 reset register");
    end
    chk(int'(irq_o), 0, "R1 reset irq");

    // R2 event while masked
    ev(20'h00008);
    rd(3'd2); chk(int'(rd_data), 'h0008, "R2 pending lo");
    chk(int'(irq_o), 0, "R7 masked no irq");
    rd(3'd4); chk(int'(rd_data), 0, "R4 vector none enabled");
    rd(3'd2); chk(int'(rd_data), 'h0008, "R5 zero vector clears nothing");

    // R3 enable words
    wr(3'd0, 16'hFFFF);
    wr(3'd1, 16'hFFFF);
    rd(3'd1); chk(int'(rd_data), 'h000F, "R3 enable hi readback");
    rd(3'd0); chk(int'(rd_data), 'hFFFF, "R3 enable lo readback");
    chk(int'(irq_o), 1, "R7 enabled pending irq");

    // R4/R5/R9 priority order and read-to-clear
    ev(20'h20020);
    rd(3'd4); chk(int'(rd_data), 4, "R4 vector src3");
    rd(3'd4); chk(int'(rd_data), 6, "R5 vector src5");
    rd(3'd3); chk(int'(rd_data), 'h0002, "R9 src17 kept");
    rd(3'd4); chk(int'(rd_data), 18, "R4 vector src17");
    chk(int'(irq_o), 0, "R7 irq falls when all cleared");
    rd(3'd4); chk(int'(rd_data), 0, "R4 vector empty");

    // R6 set wins over read-clear
    ev(20'h00004);
    cycle(20'h00004, 0, 1, 3'd4, '0);
    chk(int'(rd_data), 3, "R6 vector src2");
    rd(3'd2); chk(int'(rd_data), 'h0004, "R6 pending kept");
    wr(3'd2, 16'h0004);

    // R8 write-one-to-clear
    ev(20'h80003);
    wr(3'd2, 16'h0001);
    rd(3'd2); chk(int'(rd_data), 'h0002, "R8 lo clear");
    wr(3'd3, 16'h0000);
    rd(3'd3); chk(int'(rd_data), 'h0008, "R8 zero write no effect");
    wr(3'd3, 16'h0008);
    rd(3'd3); chk(int'(rd_data), 0, "R8 hi clear");
    wr(3'd2, 16'hFFFF);

    // R4 masking shapes priority
    wr(3'd0, 16'hFFFE);
    ev(20'h00401);
    rd(3'd4); chk(int'(rd_data), 11, "R4 masked src0 skipped");
    rd(3'd7); chk(int'(rd_data), 0, "R9 unmapped read zero");
    ev('0); chk(int'(rd_data), 0, "R9 rd_data hold");

    // random phase against the reference
    for (int i = 0; i < 3000; i++) begin
      bit [19:0] e;
      e = ($urandom_range(0, 3) == 0) ? 20'(1 << $urandom_range(0, 19)) : 20'h0;
      cycle(e, ($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0),
            3'($urandom_range(0, 7)), 16'($urandom));
    end

    finish_run();
  end
endmodule